// File: doc/BRIEF.md
# Configurable Multiplexed Bus Front End

This block sits between the pins of an 8-bit microcontroller bus and the internal logic of a peripheral. It turns asynchronous bus strobes into a stable, registered address and into single-cycle internal read and write pulses, all on the system clock. It also produces an enable for the bidirectional data pins. Address decoding and the memories behind the front end belong to other blocks.

Configuration inputs select how the bus is wired:
- **Multiplexed mode.** The low address byte shares the data pins and is captured by an address strobe.
- **Non-multiplexed mode.** The address arrives on dedicated pins.
- **Polarities.** The address strobe and the reset pin each have a programmable active level.
- **Control style.** Either separate active-low read and write strobes, or a read/write level qualified by an active-high enable.
- **Code fetch.** An active-low program-fetch strobe always requests a read.

Every pin input passes through a synchronizer chain of `SYNC_DEPTH` flops before it is used. The configuration inputs are static and may change only while reset is asserted. There is no data stream at the edge of this block: each access is one event, so no valid/ready handshake and no back-pressure apply.

Top module: `busfe_top`

## Requirements
- R1: In multiplexed mode (`cfg_mux`=1), the address is `{hi_pins, ad_in}` as sampled on the last clock where the address strobe was active. It is loaded when the strobe goes inactive.
- R2: In multiplexed mode, `addr` holds its value until the next trailing edge of the address strobe. Changes on `ad_in` or `hi_pins` during the data phase do not alter it.
- R3: In non-multiplexed mode (`cfg_mux`=0), `addr` follows `{hi_pins, lo_pins}` through the synchronizer, with no strobe needed.
- R4: `cfg_as_pol`=1 makes the address strobe active high, and `cfg_as_pol`=0 makes it active low.
- R5: Reset is active while the synchronized `rst_pin` equals `cfg_rst_pol`.
- R6: With `cfg_rw_e`=0, a low on `rd_pin` gives exactly one `rd_pulse`. A low on `wr_pin` gives exactly one `wr_pulse` at its trailing edge. At that pulse, `wdata` holds the `ad_in` value from the last active cycle.
- R7: With `cfg_rw_e`=1, `rd_pin` is an active-high enable and `wr_pin` is the read/write level (1 = read, 0 = write). The kind of access is fixed when the enable rises, so a change of the level after the enable falls does not turn a write into a read.
- R8: A low on `psen_n` gives exactly one `rd_pulse` in either control style.
- R9: `data_oe` is high during a read access, rises together with `rd_pulse`, drops within `SYNC_DEPTH`+1 clocks of the read's trailing edge, and stays low during writes.
- R10: `rd_pulse` and `wr_pulse` are each one clock wide and are never high together.
- R11: In reset, `addr`, `wdata`, `rd_pulse`, `wr_pulse` and `data_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin | input | 1 | Raw reset pin, active level set by `cfg_rst_pol` |
| cfg_rst_pol | input | 1 | Reset active level |
| cfg_mux | input | 1 | 1 = multiplexed address/data, 0 = dedicated address pins |
| cfg_as_pol | input | 1 | Address strobe active level |
| cfg_rw_e | input | 1 | 0 = separate read/write strobes, 1 = read/write level plus enable |
| as_pin | input | 1 | Address strobe pin |
| rd_pin | input | 1 | Read strobe (active low) or enable (active high) |
| wr_pin | input | 1 | Write strobe (active low) or read/write level |
| psen_n | input | 1 | Program-fetch strobe, active low |
| ad_in | input | 8 | Shared address/data pins, input side |
| lo_pins | input | 8 | Dedicated low address pins (non-multiplexed mode) |
| hi_pins | input | ADDR_W-8 | High address pins |
| addr | output | ADDR_W | Held address for decoding |
| rd_pulse | output | 1 | One-clock internal read request |
| wr_pulse | output | 1 | One-clock internal write request |
| wdata | output | 8 | Write data captured for the write pulse |
| data_oe | output | 1 | Drive enable for the data pins |

## Verification
Multiplexed reads and writes run with the address pins changed during the data phase. This separates a correct trailing-edge capture from an address register that keeps following the pins. The same access repeated with an active-low strobe, and then with the enable-qualified control style, tells the polarity and style decoding apart from a fixed default. In the enable style, a write whose level flips just after the enable falls exposes an access kind that is decided too late. Non-multiplexed address changes, program-fetch reads and a reset taken at the inverted polarity complete the set.

// File: rtl/busfe_pkg.sv
package busfe_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/busfe_sync.sv
module busfe_sync #(
  parameter int W     = 1,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) stage[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[DEPTH-1];
endmodule

// File: rtl/busfe_addr_latch.sv
module busfe_addr_latch #(
  parameter int ADDR_W = 16,
  localparam int HI_W  = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mux,
  input  logic              cfg_as_pol,
  input  logic              as_s,
  input  logic [7:0]        ad_s,
  input  logic [7:0]        lo_s,
  input  logic [HI_W-1:0]   hi_s,
  output logic [ADDR_W-1:0] addr
);
  logic              as_on, as_on_q, as_trail;
  logic [ADDR_W-1:0] shadow;

  assign as_on    = (as_s == cfg_as_pol);
  assign as_trail = as_on_q && !as_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      as_on_q <= 1'b0;
      shadow  <= '0;
      addr    <= '0;
    end else begin
      as_on_q <= as_on;
      if (as_on) shadow <= {hi_s, ad_s};
      if (!cfg_mux)      addr <= {hi_s, lo_s};
      else if (as_trail) addr <= shadow;
    end
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_mux && !as_trail) |=> $stable(addr));

  // R11
  addr_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (addr == '0));
endmodule

// File: rtl/busfe_ctrl.sv
module busfe_ctrl
  import busfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_rw_e,
  input  logic       rd_s,
  input  logic       wr_s,
  input  logic       psen_s,
  input  logic [7:0] ad_s,
  output logic       rd_pulse,
  output logic       wr_pulse,
  output logic [7:0] wdata,
  output logic       data_oe
);
  acc_e       state;
  logic       any_on, is_wr;
  logic [7:0] wshadow;

  always_comb begin
    if (cfg_rw_e) begin
      any_on = rd_s || !psen_s;
      is_wr  = rd_s && !wr_s && psen_s;
    end else begin
      any_on = !rd_s || !wr_s || !psen_s;
      is_wr  = !wr_s && rd_s && psen_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ACC_IDLE;
      rd_pulse <= 1'b0;
      wr_pulse <= 1'b0;
      wdata    <= '0;
      wshadow  <= '0;
    end else begin
      rd_pulse <= 1'b0;
      wr_pulse <= 1'b0;
      case (state)
        ACC_IDLE: if (any_on) begin
          if (is_wr) begin
            state   <= ACC_WRITE;
            wshadow <= ad_s;
          end else begin
            state    <= ACC_READ;
            rd_pulse <= 1'b1;
          end
        end
        ACC_READ: if (!any_on) state <= ACC_IDLE;
        ACC_WRITE: begin
          if (any_on) wshadow <= ad_s;
          else begin
            state    <= ACC_IDLE;
            wr_pulse <= 1'b1;
            wdata    <= wshadow;
          end
        end
        default: state <= ACC_IDLE;
      endcase
    end
  end

  assign data_oe = (state == ACC_READ);

  // R10
  no_both_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_pulse && wr_pulse));
  // R10
  rd_once_chk: assert property (@(posedge clk) disable iff (rst)
    rd_pulse |=> !rd_pulse);
  // R10
  wr_once_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |=> !wr_pulse);
  // R9
  oe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(data_oe) |-> rd_pulse);
  // R9
  oe_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    wr_pulse |-> !data_oe);
endmodule

// File: rtl/busfe_top.sv
module busfe_top #(
  parameter int ADDR_W     = 16,
  parameter int SYNC_DEPTH = 2,
  localparam int HI_W      = ADDR_W - 8,
  localparam int SW        = 4 + 1 + 8 + 8 + HI_W
) (
  input  logic              clk,
  input  logic              rst_pin,
  input  logic              cfg_rst_pol,
  input  logic              cfg_mux,
  input  logic              cfg_as_pol,
  input  logic              cfg_rw_e,
  input  logic              as_pin,
  input  logic              rd_pin,
  input  logic              wr_pin,
  input  logic              psen_n,
  input  logic [7:0]        ad_in,
  input  logic [7:0]        lo_pins,
  input  logic [HI_W-1:0]   hi_pins,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_pulse,
  output logic              wr_pulse,
  output logic [7:0]        wdata,
  output logic              data_oe
);
  logic [SW-1:0]   pins_s;
  logic            rst_s, as_s, rd_s, wr_s, psen_s, rst;
  logic [7:0]      ad_s, lo_s;
  logic [HI_W-1:0] hi_s;

  busfe_sync #(.W(SW), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .d   ({rst_pin, as_pin, rd_pin, wr_pin, psen_n, ad_in, lo_pins, hi_pins}),
    .q   (pins_s)
  );

  assign {rst_s, as_s, rd_s, wr_s, psen_s, ad_s, lo_s, hi_s} = pins_s;
  assign rst = (rst_s == cfg_rst_pol);

  busfe_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst        (rst),
    .cfg_mux    (cfg_mux),
    .cfg_as_pol (cfg_as_pol),
    .as_s       (as_s),
    .ad_s       (ad_s),
    .lo_s       (lo_s),
    .hi_s       (hi_s),
    .addr       (addr)
  );

  busfe_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cfg_rw_e (cfg_rw_e),
    .rd_s     (rd_s),
    .wr_s     (wr_s),
    .psen_s   (psen_s),
    .ad_s     (ad_s),
    .rd_pulse (rd_pulse),
    .wr_pulse (wr_pulse),
    .wdata    (wdata),
    .data_oe  (data_oe)
  );

  // R11
  outs_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> (!rd_pulse && !wr_pulse && !data_oe && wdata == 8'h00));
endmodule

// File: tb/sim_busfe_top.sv
module sim_busfe_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_pin, cfg_rst_pol, cfg_mux, cfg_as_pol, cfg_rw_e;
  logic        as_pin, rd_pin, wr_pin, psen_n;
  logic [7:0]  ad_in, lo_pins, hi_pins;
  logic [15:0] addr;
  logic        rd_pulse, wr_pulse, data_oe;
  logic [7:0]  wdata;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0;
  bit done = 0;

  busfe_top u0 (
    .clk(clk), .rst_pin(rst_pin), .cfg_rst_pol(cfg_rst_pol), .cfg_mux(cfg_mux),
    .cfg_as_pol(cfg_as_pol), .cfg_rw_e(cfg_rw_e), .as_pin(as_pin), .rd_pin(rd_pin),
    .wr_pin(wr_pin), .psen_n(psen_n), .ad_in(ad_in), .lo_pins(lo_pins),
    .hi_pins(hi_pins), .addr(addr), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
    .wdata(wdata), .data_oe(data_oe)
  );

  always @(negedge clk) begin
    if (rd_pulse) rd_cnt++;
    if (wr_pulse) wr_cnt++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_pins();
    as_pin = ~cfg_as_pol;
    rd_pin = cfg_rw_e ? 1'b0 : 1'b1;
    wr_pin = 1'b1;
    psen_n = 1'b1;
  endtask

  task automatic reconfig(input bit mux, input bit aspol, input bit rwe);
    rst_pin = cfg_rst_pol;
    step(5);
    cfg_mux = mux; cfg_as_pol = aspol; cfg_rw_e = rwe;
    idle_pins();
    step(5);
    rst_pin = ~cfg_rst_pol;
    step(5);
  endtask

  task automatic strobe_on(input bit wr);
    if (cfg_rw_e) begin
      wr_pin = ~wr;
      step(1);
      rd_pin = 1'b1;
    end else if (wr) wr_pin = 1'b0;
    else rd_pin = 1'b0;
  endtask

  task automatic strobe_off();
    if (cfg_rw_e) begin
      rd_pin = 1'b0;
      step(1);
      wr_pin = 1'b1;
    end else begin
      rd_pin = 1'b1;
      wr_pin = 1'b1;
    end
  endtask

  // Multiplexed access: latch address, then change pins during data phase.
  task automatic t_mux_access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                              input string req);
    int r0 = rd_cnt, w0 = wr_cnt;
    as_pin = cfg_as_pol; ad_in = a[7:0]; hi_pins = a[15:8];
    step(3);
    as_pin = ~cfg_as_pol;
    step(1);
    ad_in = d; hi_pins = ~a[15:8];
    strobe_on(wr);
    step(6);
    check(data_oe == !wr, {req, " R9 oe during access"}, data_oe, !wr);
    strobe_off();
    step(6);
    check(data_oe == 1'b0, "R9 oe after trailing edge", data_oe, 0);
    check(addr == a, {req, " R1 R2 latched address"}, addr, a);
    check(rd_cnt - r0 == (wr ? 0 : 1), {req, " R6 R10 read pulses"}, rd_cnt - r0, wr ? 0 : 1);
    check(wr_cnt - w0 == (wr ? 1 : 0), {req, " R6 R10 write pulses"}, wr_cnt - w0, wr ? 1 : 0);
    if (wr) check(wdata == d, {req, " R6 write data"}, wdata, d);
  endtask

  task automatic t_reset();
    check(addr == 16'h0 && wdata == 8'h0, "R11 reset addr/wdata", {addr, wdata}, 0);
    check(!rd_pulse && !wr_pulse && !data_oe, "R11 reset controls",
          {rd_pulse, wr_pulse, data_oe}, 0);
  endtask

  task automatic t_nonmux();
    lo_pins = 8'h3C; hi_pins = 8'hA5; ad_in = 8'h77;
    step(5);
    check(addr == 16'hA53C, "R3 direct address", addr, 16'hA53C);
    lo_pins = 8'hC3; hi_pins = 8'h12; ad_in = 8'h00;
    step(5);
    check(addr == 16'h12C3, "R3 direct address follows", addr, 16'h12C3);
  endtask

  task automatic t_rwe_late_level();
    int r0 = rd_cnt, w0 = wr_cnt;
    ad_in = 8'h5A;
    wr_pin = 1'b0; step(1);
    rd_pin = 1'b1; step(5);
    rd_pin = 1'b0; step(1);
    wr_pin = 1'b1; ad_in = 8'hFF;
    step(6);
    check(wr_cnt - w0 == 1 && rd_cnt == r0, "R7 write kept after level flip",
          wr_cnt - w0, 1);
    check(wdata == 8'h5A, "R7 write data", wdata, 8'h5A);
  endtask

  task automatic t_psen(input string req);
    int r0 = rd_cnt;
    psen_n = 1'b0;
    step(6);
    check(data_oe == 1'b1, {req, " R8 oe on fetch"}, data_oe, 1);
    psen_n = 1'b1;
    step(6);
    check(rd_cnt - r0 == 1 && !data_oe, {req, " R8 one fetch read"}, rd_cnt - r0, 1);
  endtask

  task automatic t_rst_pol();
    rst_pin = 1'b0; cfg_rst_pol = 1'b0;
    step(5);
    check(addr == 16'h0, "R5 low-active reset clears addr", addr, 0);
    rst_pin = 1'b1;
    step(5);
    t_mux_access(1'b0, 16'h6E19, 8'h44, "R5 out of reset with pin high");
  endtask

  initial begin
    cfg_rst_pol = 1'b1; rst_pin = 1'b1;
    cfg_mux = 1'b1; cfg_as_pol = 1'b1; cfg_rw_e = 1'b0;
    ad_in = 8'h00; lo_pins = 8'h00; hi_pins = 8'h00;
    idle_pins();
    step(8);
    t_reset();
    rst_pin = 1'b0;
    step(5);
    t_mux_access(1'b0, 16'hBEEF, 8'h11, "R1 read");
    t_mux_access(1'b1, 16'h1234, 8'hC7, "R6 write");
    t_psen("R8 style0");
    reconfig(1'b1, 1'b0, 1'b0);
    t_mux_access(1'b0, 16'h4321, 8'h99, "R4 low strobe");
    reconfig(1'b0, 1'b1, 1'b0);
    t_nonmux();
    reconfig(1'b1, 1'b1, 1'b1);
    t_mux_access(1'b0, 16'h0F0E, 8'h21, "R7 read");
    t_mux_access(1'b1, 16'h8001, 8'h3D, "R7 write");
    t_rwe_late_level();
    t_psen("R8 style1");
    reconfig(1'b1, 1'b1, 1'b0);
    t_rst_pol();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule